// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pair Issuer

This block sits between instruction fetch and execution in a two-way in-order superscalar front end. Every cycle fetch presents one aligned 64-bit pair of 32-bit instructions. Each slot arrives already decoded into a class, a destination register and two source registers. The low slot may carry any class. The high slot can issue alongside it only when it is a floating-point operation. Each cycle the block decides whether the pair issues whole, issues only the low slot, or issues nothing.

Issue order never changes. The high slot issues only when the low slot issues in the same cycle. A high instruction that cannot pair is not dropped. The pair is held at fetch, and in the next group the high instruction issues by itself in the low issue position. Loads have a one-cycle delay. The destination of a load issued in one cycle is tracked for exactly one following cycle. Any consumer of that register in the next group waits, and so does the partner slot in the same group that reads it. One load therefore shadows three instruction positions.

Top module: `pair_issuer`

## Requirements
- R1: With `pair_valid` low, `issue_lo`, `issue_hi` and `fetch_stall` are all low. After reset no load is tracked, so the first valid group is never held for a load.
- R2: The class encoding is 0 = integer op, 1 = integer load, 2 = FP op, 3 = FP load. FP ops and FP loads write the FP register file. Integer ops and integer loads write the integer file. FP ops read both sources from the FP file. Integer ops read both sources from the integer file. Both load classes read only source A, from the integer file.
- R3: An integer op or integer load in the low slot with an independent FP op in the high slot issues both slots in one cycle, with `fetch_stall` low.
- R4: An FP load in the low slot and an independent FP op in the high slot issue together in one cycle.
- R5: If the high slot is not an FP op, or the low slot is also an FP op, only the low slot issues and `fetch_stall` is high. In the next cycle the high instruction issues alone on `issue_lo`, and `fetch_stall` is low once it issues.
- R6: `issue_hi` is never high without `issue_lo`. When the low instruction is blocked, nothing issues, `fetch_stall` is high, and the same group is retried the next cycle.
- R7: A high FP op that reads the destination of a load in the low slot of the same group does not issue with it and is retried as in R5.
- R8: A load issued in cycle t blocks any instruction in the group considered in cycle t+1 that reads its destination in the same file. A blocked low instruction stalls the whole group. A blocked high instruction is split off as in R5.
- R9: Hazards match on both register file and index: an FP read of register n is not blocked by an integer load of register n. Source B of a load is ignored.
- R10: A load shadow lasts exactly one cycle. After any cycle that issues no load, including an idle cycle or a stall, a reader of that register is not blocked.
- R11: A retried high instruction is itself checked against a load issued in the previous cycle, so a split caused by an in-group load is followed by one empty cycle before the retried instruction issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | Fetched pair present and stable |
| lo_cls | input | 2 | Low slot class (R2 encoding) |
| lo_dst | input | REG_W | Low slot destination register |
| lo_src_a | input | REG_W | Low slot source A |
| lo_src_b | input | REG_W | Low slot source B |
| hi_cls | input | 2 | High slot class |
| hi_dst | input | REG_W | High slot destination register |
| hi_src_a | input | REG_W | High slot source A |
| hi_src_b | input | REG_W | High slot source B |
| issue_lo | output | 1 | Low issue position fires this cycle |
| issue_hi | output | 1 | High issue position fires this cycle |
| fetch_stall | output | 1 | Pair not consumed; fetch holds it |

## Verification
The block keeps only two state bits that matter: the retry flag and the one-entry load shadow. A stuck retry flag shows up in the very next cycle in two ways: a lone `issue_lo` with the stall still high, or a high instruction issued twice. A shadow that lives too long or matches on the wrong file shows up as a stall cycle on a group that should have issued, exactly one cycle after the load. A shadow that is missing shows up as an issue of a dependent group that should have waited. Every check therefore lands within one or two cycles of the stimulus that caused it.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_LD   = 2'd1,
    CLS_FP   = 2'd2,
    CLS_FPLD = 2'd3
  } op_cls_e;

  // destination lives in the FP file
  function automatic logic dst_is_fp(op_cls_e c);
    return (c == CLS_FP) || (c == CLS_FPLD);
  endfunction

  // sources are read from the FP file
  function automatic logic src_is_fp(op_cls_e c);
    return c == CLS_FP;
  endfunction

  // source B is a real operand (loads only use the base)
  function automatic logic uses_src_b(op_cls_e c);
    return (c == CLS_INT) || (c == CLS_FP);
  endfunction

  function automatic logic is_load(op_cls_e c);
    return (c == CLS_LD) || (c == CLS_FPLD);
  endfunction

endpackage

// File: rtl/issue_load_shadow.sv
module issue_load_shadow #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             set_fp_i,
  input  logic [REG_W-1:0] set_dst_i,
  output logic             busy_o,
  output logic             busy_fp_o,
  output logic [REG_W-1:0] busy_dst_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      busy_fp_o  <= 1'b0;
      busy_dst_o <= '0;
    end else begin
      busy_o     <= set_i;
      busy_fp_o  <= set_fp_i;
      busy_dst_o <= set_dst_i;
    end
  end

endmodule

// File: rtl/issue_pair_rules.sv
module issue_pair_rules
  import pair_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  op_cls_e          a_cls,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_src_a,
  input  logic [REG_W-1:0] a_src_b,
  input  logic             b_present,
  input  op_cls_e          b_cls,
  input  logic [REG_W-1:0] b_src_a,
  input  logic [REG_W-1:0] b_src_b,
  input  logic             shd_busy,
  input  logic             shd_fp,
  input  logic [REG_W-1:0] shd_dst,
  output logic             a_blocked,
  output logic             b_pairs
);

  function automatic logic reads_reg(op_cls_e c, logic [REG_W-1:0] sa,
                                     logic [REG_W-1:0] sb, logic fp,
                                     logic [REG_W-1:0] d);
    return (src_is_fp(c) == fp) && ((sa == d) || (uses_src_b(c) && (sb == d)));
  endfunction

  logic b_type_ok, b_intra_use, b_prev_use;

  assign b_type_ok   = (b_cls == CLS_FP) && (a_cls != CLS_FP);
  assign b_intra_use = is_load(a_cls) &&
                       reads_reg(b_cls, b_src_a, b_src_b, dst_is_fp(a_cls), a_dst);
  assign b_prev_use  = shd_busy && reads_reg(b_cls, b_src_a, b_src_b, shd_fp, shd_dst);

  assign a_blocked = shd_busy && reads_reg(a_cls, a_src_a, a_src_b, shd_fp, shd_dst);
  assign b_pairs   = b_present && b_type_ok && !b_intra_use && !b_prev_use;

endmodule

// File: rtl/pair_issuer.sv
module pair_issuer
  import pair_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_valid,
  input  logic [1:0]       lo_cls,
  input  logic [REG_W-1:0] lo_dst,
  input  logic [REG_W-1:0] lo_src_a,
  input  logic [REG_W-1:0] lo_src_b,
  input  logic [1:0]       hi_cls,
  input  logic [REG_W-1:0] hi_dst,
  input  logic [REG_W-1:0] hi_src_a,
  input  logic [REG_W-1:0] hi_src_b,
  output logic             issue_lo,
  output logic             issue_hi,
  output logic             fetch_stall
);

  logic             retry_q;
  op_cls_e          eff_cls;
  logic [REG_W-1:0] eff_dst, eff_src_a, eff_src_b;
  logic             shd_busy, shd_fp;
  logic [REG_W-1:0] shd_dst;
  logic             lo_blocked, hi_pairs, load_fire, consumed;

  // after a split the held high instruction moves to the low position
  assign eff_cls   = retry_q ? op_cls_e'(hi_cls) : op_cls_e'(lo_cls);
  assign eff_dst   = retry_q ? hi_dst   : lo_dst;
  assign eff_src_a = retry_q ? hi_src_a : lo_src_a;
  assign eff_src_b = retry_q ? hi_src_b : lo_src_b;

  issue_pair_rules #(.REG_W(REG_W)) u_rules (
    .a_cls     (eff_cls),
    .a_dst     (eff_dst),
    .a_src_a   (eff_src_a),
    .a_src_b   (eff_src_b),
    .b_present (!retry_q),
    .b_cls     (op_cls_e'(hi_cls)),
    .b_src_a   (hi_src_a),
    .b_src_b   (hi_src_b),
    .shd_busy  (shd_busy),
    .shd_fp    (shd_fp),
    .shd_dst   (shd_dst),
    .a_blocked (lo_blocked),
    .b_pairs   (hi_pairs)
  );

  assign issue_lo    = pair_valid && !lo_blocked;
  assign issue_hi    = issue_lo && hi_pairs;
  assign consumed    = issue_hi || (issue_lo && retry_q);
  assign fetch_stall = pair_valid && !consumed;
  assign load_fire   = issue_lo && is_load(eff_cls);

  issue_load_shadow #(.REG_W(REG_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (load_fire),
    .set_fp_i   (dst_is_fp(eff_cls)),
    .set_dst_i  (eff_dst),
    .busy_o     (shd_busy),
    .busy_fp_o  (shd_fp),
    .busy_dst_o (shd_dst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        retry_q <= 1'b0;
    else if (issue_lo) retry_q <= !retry_q && !issue_hi;
  end

endmodule

// File: rtl/pair_issuer_chk.sv
module pair_issuer_chk
  import pair_issue_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pair_valid,
  input logic [1:0]       lo_cls,
  input logic [REG_W-1:0] lo_dst,
  input logic [1:0]       hi_cls,
  input logic [REG_W-1:0] hi_src_a,
  input logic [REG_W-1:0] hi_src_b,
  input logic             retry_q,
  input op_cls_e          eff_cls,
  input logic [REG_W-1:0] eff_dst,
  input logic [REG_W-1:0] eff_src_a,
  input logic [REG_W-1:0] eff_src_b,
  input logic             issue_lo,
  input logic             issue_hi,
  input logic             fetch_stall
);

  function automatic logic touches(op_cls_e c, logic [REG_W-1:0] sa,
                                   logic [REG_W-1:0] sb, logic fp,
                                   logic [REG_W-1:0] d);
    return (src_is_fp(c) == fp) && ((sa == d) || (uses_src_b(c) && (sb == d)));
  endfunction

  // independent record of the last issued load, built from issue events
  logic             mon_ld_v, mon_ld_fp;
  logic [REG_W-1:0] mon_ld_dst;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_ld_v   <= 1'b0;
      mon_ld_fp  <= 1'b0;
      mon_ld_dst <= '0;
    end else begin
      mon_ld_v   <= issue_lo && is_load(eff_cls);
      mon_ld_fp  <= dst_is_fp(eff_cls);
      mon_ld_dst <= eff_dst;
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> (!issue_lo && !issue_hi && !fetch_stall));

  p_hi_needs_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hi |-> (issue_lo && !fetch_stall));

  p_one_fp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hi |-> (!retry_q && op_cls_e'(hi_cls) == CLS_FP && op_cls_e'(lo_cls) != CLS_FP));

  p_split_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_lo && !issue_hi && !retry_q) |=> retry_q);

  p_intra_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hi |-> !(is_load(op_cls_e'(lo_cls)) &&
      touches(op_cls_e'(hi_cls), hi_src_a, hi_src_b, dst_is_fp(op_cls_e'(lo_cls)), lo_dst)));

  p_shadow_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mon_ld_v |-> !(issue_lo && touches(eff_cls, eff_src_a, eff_src_b, mon_ld_fp, mon_ld_dst)));

  p_shadow_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mon_ld_v |-> !(issue_hi &&
      touches(op_cls_e'(hi_cls), hi_src_a, hi_src_b, mon_ld_fp, mon_ld_dst)));

endmodule

bind pair_issuer pair_issuer_chk #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pair_valid  (pair_valid),
  .lo_cls      (lo_cls),
  .lo_dst      (lo_dst),
  .hi_cls      (hi_cls),
  .hi_src_a    (hi_src_a),
  .hi_src_b    (hi_src_b),
  .retry_q     (retry_q),
  .eff_cls     (eff_cls),
  .eff_dst     (eff_dst),
  .eff_src_a   (eff_src_a),
  .eff_src_b   (eff_src_b),
  .issue_lo    (issue_lo),
  .issue_hi    (issue_hi),
  .fetch_stall (fetch_stall)
);

// File: tb/pair_issuer_tb_top.sv
module pair_issuer_tb_top;

  localparam int RW = 5;
  localparam logic [1:0] I = 2'd0, L = 2'd1, F = 2'd2, FL = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pair_valid = 1'b0;
  logic [1:0] lo_cls = '0, hi_cls = '0;
  logic [RW-1:0] lo_dst = '0, lo_src_a = '0, lo_src_b = '0;
  logic [RW-1:0] hi_dst = '0, hi_src_a = '0, hi_src_b = '0;
  logic issue_lo, issue_hi, fetch_stall;

  always #2 clk = ~clk;

  pair_issuer #(.REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
    .lo_cls(lo_cls), .lo_dst(lo_dst), .lo_src_a(lo_src_a), .lo_src_b(lo_src_b),
    .hi_cls(hi_cls), .hi_dst(hi_dst), .hi_src_a(hi_src_a), .hi_src_b(hi_src_b),
    .issue_lo(issue_lo), .issue_hi(issue_hi), .fetch_stall(fetch_stall)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  // drive one cycle of stimulus and queue its expected {lo, hi, stall}
  task automatic step(input logic v,
                      input logic [1:0] lc, input int ld, input int la, input int lb,
                      input logic [1:0] hc, input int hd, input int ha, input int hb,
                      input logic [2:0] exp, input string tag);
    @(negedge clk);
    pair_valid = v;
    lo_cls = lc; lo_dst = RW'(ld); lo_src_a = RW'(la); lo_src_b = RW'(lb);
    hi_cls = hc; hi_dst = RW'(hd); hi_src_a = RW'(ha); hi_src_b = RW'(hb);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: compare outputs after inputs settle, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {issue_lo, issue_hi, fetch_stall};
        n_checks++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: {lo,hi,stall} actual %b expected %b", t, a, e);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(0, I,0,0,0, F,0,0,0, 3'b000, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(0, I,0,0,0, F,0,0,0, 3'b000, "R1");
    // first group after reset reads reg 0 of both files: no shadow
    step(1, I,1,0,0, F,1,0,0, 3'b110, "R1");
    step(1, L,4,5,0, F,4,5,6, 3'b110, "R2");   // int load x4
    step(1, I,6,7,8, F,8,4,4, 3'b110, "R9");   // fp read of f4 vs int x4
    step(1, FL,10,1,0, F,11,10,2, 3'b101, "R7"); // in-group use of f10
    step(1, FL,10,1,0, F,11,10,2, 3'b001, "R11"); // retried op still shadowed
    step(1, FL,10,1,0, F,11,10,2, 3'b100, "R11");
    step(1, FL,12,1,0, F,13,2,3, 3'b110, "R4");
    step(1, I,9,1,2, F,14,12,1, 3'b101, "R8");  // high reads f12 of previous load
    step(1, I,9,1,2, F,14,12,1, 3'b100, "R8");
    step(1, L,3,2,0, F,1,2,3, 3'b110, "R3");
    step(1, I,5,6,3, F,2,1,1, 3'b001, "R8");   // low reads x3: whole group waits
    step(1, I,5,6,3, F,2,1,1, 3'b110, "R6");
    step(1, F,1,2,3, F,4,5,6, 3'b101, "R5");   // two FP ops
    step(1, F,1,2,3, F,4,5,6, 3'b100, "R5");
    step(1, I,1,3,4, I,2,3,4, 3'b101, "R5");   // high is not FP
    step(1, I,1,3,4, I,2,3,4, 3'b100, "R5");
    step(1, L,7,1,0, F,9,1,2, 3'b110, "R3");
    step(1, L,8,2,7, F,9,1,2, 3'b110, "R9");   // src B of load ignored
    step(0, I,0,0,0, F,0,0,0, 3'b000, "R10");
    step(1, I,1,8,8, F,3,1,2, 3'b110, "R10");  // shadow of x8 expired
    step(1, I,2,1,1, FL,20,3,0, 3'b101, "R5"); // FP load in high slot
    step(1, I,2,1,1, FL,20,3,0, 3'b100, "R5");
    step(1, I,4,1,1, F,5,20,1, 3'b101, "R8");  // retried load is tracked
    step(1, I,4,1,1, F,5,20,1, 3'b100, "R8");
    step(1, I,4,1,1, F,5,2,1, 3'b110, "R3");
    step(0, I,0,0,0, F,0,0,0, 3'b000, "R1");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule